// File: doc/BRIEF.md
# Instruction TLB Pseudo-LRU Replacement Tracker

This block keeps the recency state for a four-entry fully associative instruction TLB. The state is a six-bit field at the top of a 32-bit MMU control word, bits 31:26. Each field bit records the relative age of one pair of entries. The pairs are ordered (0,1), (0,2), (0,3), (1,2), (1,3), (2,3), from field bit 5 down to field bit 0. A 0 means the lower-numbered entry of the pair was used more recently, and a 1 means the higher-numbered one was.

A lookup hit strobes `hit_vld` with the index of the entry that matched. The tracker then marks that entry as the newest one. When the TLB needs to refill an entry, the tracker offers the least recently used entry on `victim_idx` as a combinational output. When `refill_req` is strobed, that victim is marked as used at the same clock edge.

Software can overwrite the whole control word through `cfg_wr`. Bits 25:0 of the word are only stored and returned; the tracker never changes them. If software loads an inconsistent field, `state_bad` is raised and entry 0 is offered as the victim. All pins are plain control and status signals, with no handshake.

Top module: `itlb_plru_tracker`

## Requirements
- R1: After reset, `ctrl_q` equals `CTRL_RST` (all zero by default). With that value, `use_bits` is 0, `victim_idx` is 3 and `state_bad` is 0.
- R2: A hit on entry 0 clears field bits 5, 4 and 3 at the next edge and leaves field bits 2:0 unchanged. Field bit k is `ctrl_q[26+k]`.
- R3: A hit on entry 1 sets field bit 5, clears field bits 2 and 1, and leaves field bits 4, 3 and 0 unchanged.
- R4: A hit on entry 2 sets field bits 4 and 2, clears field bit 0, and leaves field bits 5, 3 and 1 unchanged.
- R5: A hit on entry 3 sets field bits 3, 1 and 0 and leaves field bits 5, 4 and 2 unchanged.
- R6: `victim_idx` is decoded combinationally from the field as follows:
  - 0 when field bits 5, 4 and 3 are all 1;
  - 1 when field bit 5 is 0 and field bits 2 and 1 are 1;
  - 2 when field bits 4 and 2 are 0 and field bit 0 is 1;
  - 3 when field bits 3, 1 and 0 are all 0.
- R7: When the field matches none of the R6 patterns, `state_bad` is 1 and `victim_idx` is 0. Otherwise `state_bad` is 0.
- R8: `refill_req` updates the field at the next edge exactly as a hit on the entry shown on `victim_idx` before that edge would.
- R9: `cfg_wr` loads `cfg_wdata` into the whole of `ctrl_q` at the next edge. The write takes priority over a hit or a refill in the same cycle.
- R10: When a refill and a hit arrive in the same cycle without a write, only the refill update is applied.
- R11: `ctrl_q[25:0]` changes only through a software write.
- R12: A cycle with no write, no hit and no refill leaves `ctrl_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_vld | input | 1 | Lookup hit strobe |
| hit_idx | input | 2 | Index of the entry that hit |
| refill_req | input | 1 | Refill strobe; uses and marks `victim_idx` |
| cfg_wr | input | 1 | Software write strobe for the control word |
| cfg_wdata | input | 32 | Control word value to write |
| ctrl_q | output | 32 | Current control word |
| use_bits | output | 6 | Current recency field, `ctrl_q[31:26]` |
| victim_idx | output | 2 | Entry to replace on the next refill |
| state_bad | output | 1 | Field matches no victim pattern |

## Verification
The retirement check assumes the field held a consistent ordering before the refill: a refill that starts from a state where `state_bad` is 1 is excluded from it. The hit-update checks assume the hit arrives without a write or refill in the same cycle, so that the update they check is not masked by one of those. The stimulus changes inputs only on the falling clock edge and holds each strobe for exactly one cycle. It reaches an inconsistent field only by a software write, and then leaves it through a refill, so every assumed condition holds for the checks that depend on it.

// File: rtl/plru_pkg.sv
package plru_pkg;

  localparam int unsigned ENTRIES = 4;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam int unsigned USE_W   = ENTRIES * (ENTRIES - 1) / 2;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [USE_W-1:0] use_t;

  // Field bit that orders entries lo < hi; pairs are laid out from the MSB down.
  function automatic int unsigned pair_bit(int unsigned lo, int unsigned hi);
    return USE_W - 1 - (lo * (2 * ENTRIES - lo - 1) / 2 + (hi - lo - 1));
  endfunction

  // Bits that involve entry e.
  function automatic use_t lru_mask(int unsigned e);
    use_t m;
    m = '0;
    for (int unsigned j = 0; j < ENTRIES; j++) begin
      if (j < e)      m[pair_bit(j, e)] = 1'b1;
      else if (j > e) m[pair_bit(e, j)] = 1'b1;
    end
    return m;
  endfunction

  // Values of those bits when entry e is older than every other entry.
  function automatic use_t lru_val(int unsigned e);
    use_t v;
    v = '0;
    for (int unsigned j = e + 1; j < ENTRIES; j++) v[pair_bit(e, j)] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/plru_touch.sv
module plru_touch
  import plru_pkg::*;
(
  input  use_t cur,
  input  idx_t sel,
  output use_t nxt
);

  // Each pair bit moves toward the entry just used; other pairs hold.
  for (genvar lo = 0; lo < ENTRIES; lo++) begin : g_lo
    for (genvar hi = lo + 1; hi < ENTRIES; hi++) begin : g_hi
      localparam int unsigned B = pair_bit(lo, hi);
      assign nxt[B] = (sel == idx_t'(lo)) ? 1'b0 :
                      (sel == idx_t'(hi)) ? 1'b1 : cur[B];
    end
  end

endmodule

// File: rtl/plru_pick.sv
module plru_pick
  import plru_pkg::*;
(
  input  use_t cur,
  output idx_t victim,
  output logic bad
);

  logic [ENTRIES-1:0] oldest;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam use_t M = lru_mask(e);
    localparam use_t V = lru_val(e);
    assign oldest[e] = ((cur & M) == V);
  end

  // Lowest matching index wins; no match falls back to entry 0.
  always_comb begin
    victim = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (oldest[e]) victim = idx_t'(e);
    end
  end

  assign bad = ~|oldest;

endmodule

// File: rtl/itlb_plru_tracker.sv
module itlb_plru_tracker
  import plru_pkg::*;
#(
  parameter int unsigned        CTRL_W   = 32,
  parameter int unsigned        USE_LSB  = 26,
  parameter logic [CTRL_W-1:0]  CTRL_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_vld,
  input  logic [1:0]        hit_idx,
  input  logic              refill_req,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [5:0]        use_bits,
  output logic [1:0]        victim_idx,
  output logic              state_bad
);

  localparam int unsigned USE_MSB = USE_LSB + USE_W - 1;

  logic [CTRL_W-1:0] ctrl_r;
  logic [CTRL_W-1:0] ctrl_n;
  use_t              cur_use;
  use_t              new_use;
  idx_t              pick;
  idx_t              touch_sel;
  logic              pick_bad;

  assign cur_use = ctrl_r[USE_MSB:USE_LSB];

  plru_pick u_pick (
    .cur    (cur_use),
    .victim (pick),
    .bad    (pick_bad)
  );

  // A refill marks the entry it replaces; otherwise the hit entry.
  assign touch_sel = refill_req ? pick : idx_t'(hit_idx);

  plru_touch u_touch (
    .cur (cur_use),
    .sel (touch_sel),
    .nxt (new_use)
  );

  always_comb begin
    ctrl_n = ctrl_r;
    if (cfg_wr) begin
      ctrl_n = cfg_wdata;
    end else if (refill_req || hit_vld) begin
      ctrl_n[USE_MSB:USE_LSB] = new_use;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_r <= CTRL_RST;
    else        ctrl_r <= ctrl_n;
  end

  assign ctrl_q     = ctrl_r;
  assign use_bits   = cur_use;
  assign victim_idx = pick;
  assign state_bad  = pick_bad;

endmodule

// File: rtl/itlb_plru_tracker_chk.sv
module itlb_plru_tracker_chk #(
  parameter int unsigned CTRL_W  = 32,
  parameter int unsigned USE_LSB = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit_vld,
  input logic [1:0]        hit_idx,
  input logic              refill_req,
  input logic              cfg_wr,
  input logic [CTRL_W-1:0] cfg_wdata,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [5:0]        use_bits,
  input logic [1:0]        victim_idx,
  input logic              state_bad
);

  logic plain_hit;
  assign plain_hit = hit_vld && !cfg_wr && !refill_req;

  a_r2_hit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    plain_hit && hit_idx == 2'd0 |=>
      use_bits[5:3] == 3'b000 && use_bits[2:0] == $past(use_bits[2:0]));

  a_r3_hit_one: assert property (@(posedge clk) disable iff (!rst_n)
    plain_hit && hit_idx == 2'd1 |=>
      use_bits[5] && use_bits[2:1] == 2'b00 &&
      use_bits[4:3] == $past(use_bits[4:3]) && use_bits[0] == $past(use_bits[0]));

  a_r4_hit_two: assert property (@(posedge clk) disable iff (!rst_n)
    plain_hit && hit_idx == 2'd2 |=>
      use_bits[4] && use_bits[2] && !use_bits[0] &&
      use_bits[5] == $past(use_bits[5]) && use_bits[3] == $past(use_bits[3]) &&
      use_bits[1] == $past(use_bits[1]));

  a_r5_hit_three: assert property (@(posedge clk) disable iff (!rst_n)
    plain_hit && hit_idx == 2'd3 |=>
      use_bits[3] && use_bits[1] && use_bits[0] &&
      use_bits[5:4] == $past(use_bits[5:4]) && use_bits[2] == $past(use_bits[2]));

  a_r7_bad_picks_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state_bad |-> victim_idx == 2'd0);

  a_r8_refill_retires: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req && !cfg_wr && !state_bad |=> victim_idx != $past(victim_idx));

  a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> ctrl_q == $past(cfg_wdata));

  a_r11_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ctrl_q[USE_LSB-1:0] == $past(ctrl_q[USE_LSB-1:0]));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr && !hit_vld && !refill_req |=> $stable(ctrl_q));

endmodule

bind itlb_plru_tracker itlb_plru_tracker_chk #(
  .CTRL_W  (CTRL_W),
  .USE_LSB (USE_LSB)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_vld    (hit_vld),
  .hit_idx    (hit_idx),
  .refill_req (refill_req),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .ctrl_q     (ctrl_q),
  .use_bits   (use_bits),
  .victim_idx (victim_idx),
  .state_bad  (state_bad)
);

// File: tb/test_itlb_plru_tracker.sv
module test_itlb_plru_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hit_vld = 1'b0;
  logic [1:0]  hit_idx = '0;
  logic        refill_req = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] ctrl_q;
  logic [5:0]  use_bits;
  logic [1:0]  victim_idx;
  logic        state_bad;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  itlb_plru_tracker i_itlb_plru_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_vld    (hit_vld),
    .hit_idx    (hit_idx),
    .refill_req (refill_req),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .ctrl_q     (ctrl_q),
    .use_bits   (use_bits),
    .victim_idx (victim_idx),
    .state_bad  (state_bad)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic        wr;
    logic [31:0] wd;
    logic        hit;
    logic [1:0]  idx;
    logic        rf;
    logic [31:0] ectrl;
    logic [1:0]  evic;
    logic        ebad;
  } row_t;

  localparam int NROWS = 14;
  localparam row_t TBL [NROWS] = '{
    '{4'd2,  1'b0, 32'h0,        1'b1, 2'd0, 1'b0, 32'h0000_0000, 2'd3, 1'b0}, // R2 hit 0
    '{4'd5,  1'b0, 32'h0,        1'b1, 2'd3, 1'b0, 32'h2C00_0000, 2'd2, 1'b0}, // R5 hit 3
    '{4'd4,  1'b0, 32'h0,        1'b1, 2'd2, 1'b0, 32'h7800_0000, 2'd1, 1'b0}, // R4 hit 2
    '{4'd8,  1'b0, 32'h0,        1'b0, 2'd0, 1'b1, 32'hE000_0000, 2'd0, 1'b0}, // R8 refill entry 1
    '{4'd8,  1'b0, 32'h0,        1'b0, 2'd0, 1'b1, 32'h0000_0000, 2'd3, 1'b0}, // R8 refill entry 0
    '{4'd3,  1'b0, 32'h0,        1'b1, 2'd1, 1'b0, 32'h8000_0000, 2'd3, 1'b0}, // R3 hit 1
    '{4'd8,  1'b0, 32'h0,        1'b0, 2'd0, 1'b1, 32'hAC00_0000, 2'd2, 1'b0}, // R8 refill entry 3
    '{4'd7,  1'b1, 32'h6123_4567, 1'b0, 2'd0, 1'b0, 32'h6123_4567, 2'd0, 1'b1}, // R7 inconsistent field
    '{4'd11, 1'b0, 32'h0,        1'b0, 2'd0, 1'b1, 32'h0123_4567, 2'd3, 1'b0}, // R11 low bits kept
    '{4'd9,  1'b1, 32'hFC00_0000, 1'b1, 2'd0, 1'b0, 32'hFC00_0000, 2'd0, 1'b0}, // R9 write beats hit
    '{4'd10, 1'b0, 32'h0,        1'b1, 2'd3, 1'b1, 32'h1C00_0000, 2'd1, 1'b0}, // R10 refill beats hit
    '{4'd12, 1'b0, 32'h0,        1'b0, 2'd0, 1'b0, 32'h1C00_0000, 2'd1, 1'b0}, // R12 idle hold
    '{4'd9,  1'b1, 32'h0,        1'b0, 2'd0, 1'b1, 32'h0000_0000, 2'd3, 1'b0}, // R9 write beats refill
    '{4'd4,  1'b0, 32'h0,        1'b1, 2'd2, 1'b0, 32'h5000_0000, 2'd3, 1'b0}  // R4 hit 2 from reset order
  };

  function automatic string req_name(logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", ctrl_q, 32'h0);
    chk("R1", {30'd0, victim_idx}, 32'd3);
    chk("R1", {31'd0, state_bad}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", ctrl_q, 32'h0);

    for (int r = 0; r < NROWS; r++) begin
      cfg_wr     = TBL[r].wr;
      cfg_wdata  = TBL[r].wd;
      hit_vld    = TBL[r].hit;
      hit_idx    = TBL[r].idx;
      refill_req = TBL[r].rf;
      @(negedge clk);
      cfg_wr = 1'b0; hit_vld = 1'b0; refill_req = 1'b0;
      chk(req_name(TBL[r].tag), ctrl_q, TBL[r].ectrl);
      chk(req_name(TBL[r].tag), {26'd0, use_bits}, {26'd0, TBL[r].ectrl[31:26]});
      chk("R6", {30'd0, victim_idx}, {30'd0, TBL[r].evic});
      chk("R7", {31'd0, state_bad}, {31'd0, TBL[r].ebad});
    end

    // R1 reset in mid-run restores the default word
    cfg_wr = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R9", ctrl_q, 32'hFFFF_FFFF);
    chk("R6", {30'd0, victim_idx}, 32'd0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", ctrl_q, 32'h0);
    chk("R1", {30'd0, victim_idx}, 32'd3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", ctrl_q, 32'h0);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

endmodule